// File: doc/BRIEF.md
# Delta-Stream Averaging Encoder

This block combines a group of one-bit delta-modulated streams into a single delta-modulated stream. The decoded value of the output tracks the mean of the decoded inputs. On every sample clock it counts how many of the active inputs are 1. It adds that count to a small wrapping accumulator and emits the wrap-around carry as the output bit. Treating each ±1 input symbol as a plain 0/1 bit builds the slope bias into the count. As a result, the accumulator works as a digital delta encoder that takes half the ±1 input sum and uses a step height of half the active input count.

A span selector picks how many inputs take part: a power of two from one up to the full width. Inputs above the chosen span are masked to zero inside the block, so the caller does not have to tie them off. The accumulator modulus follows the chosen span. Its reset value is half that modulus, which centres the initial encoding error. The span is a configuration input and is changed only while reset is asserted.

Top module: `dm_average_adder`

## Requirements
- R1: The per-sample increment is the number of 1 bits among the active inputs, where a logic 1 stands for the symbol +1 and a logic 0 for −1.
- R2: With S the active span, the registered output bit that appears after a clock edge is 1 exactly when the accumulator value before that edge plus the increment sampled at that edge is at least S.
- R3: The accumulator wraps modulo S: after each edge it holds (previous value + increment) minus S when the output bit is 1, and the plain sum otherwise, so it always stays below S.
- R4: While reset is high, the accumulator loads S/2 (rounded down) and the output bit is 0.
- R5: When all active inputs are 1 the output bit after the edge is 1, and when all active inputs are 0 it is 0.
- R6: A span code k selects S = 2^k active inputs, namely indices 0 to S−1. Inputs at index S and above have no effect on the output.
- R7: A span code above log2 of the input count acts as the full width.
- R8: With the active inputs taken as ±1, S times the running sum of the output ±1 values minus the running sum of the input ±1 values stays within ±S from reset onward. This means the decoded output stays within one step of the decoded mean.
- R9: With span code 0, the output bit after each edge equals input 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | NUM_IN | One bit per input stream, 1 meaning +1 |
| tap_sel | input | $clog2($clog2(NUM_IN)+1) | Span code k, active inputs 2^k |
| dm_out | output | 1 | Registered averaged delta stream bit |

## Verification
The accumulator wrap and the output carry are one event: a step that crosses the modulus must emit a 1 and leave the remainder in the same edge. Holding a fixed count such as 3 of 8 forces the wrap at an irregular rhythm. All-ones drives a wrap on every cycle, and random streams land on both sides of the boundary. The bench model applies the same two rules with plain integers and compares the output on every clock. It also keeps the running error sum that must stay within one step, which catches a late or lost carry.

// File: rtl/dm_avg_pkg.sv
package dm_avg_pkg;

  // Clamp a span code to the widest span the block supports.
  function automatic int unsigned clamp_span(int unsigned code, int unsigned max_code);
    return (code > max_code) ? max_code : code;
  endfunction

endpackage

// File: rtl/dm_avg_mask.sv
module dm_avg_mask #(
  parameter int NUM_IN = 16,
  parameter int SEL_W  = 3
) (
  input  logic [NUM_IN-1:0] din,
  input  logic [SEL_W-1:0]  span,
  output logic [NUM_IN-1:0] dmask
);

  // Inputs outside the active span count as zero.
  for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
    assign dmask[i] = din[i] & (32'(i) < (32'd1 << span));
  end

endmodule

// File: rtl/dm_avg_tree.sv
module dm_avg_tree #(
  parameter int NUM_IN = 16,
  localparam int LOG2N = $clog2(NUM_IN),
  localparam int CNT_W = LOG2N + 1
) (
  input  logic [NUM_IN-1:0] bits,
  output logic [CNT_W-1:0]  count
);

  // Level l holds NUM_IN>>l partial counts, each l+1 bits wide.
  for (genvar l = 0; l <= LOG2N; l++) begin : g_lvl
    localparam int NODES = NUM_IN >> l;
    logic [l:0] sum [NODES];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < NODES; i++) begin : g_n
        assign sum[i] = bits[i];
      end
    end else begin : g_add
      for (genvar i = 0; i < NODES; i++) begin : g_n
        assign sum[i] = {1'b0, g_lvl[l-1].sum[2*i]} + {1'b0, g_lvl[l-1].sum[2*i+1]};
      end
    end
  end

  assign count = g_lvl[LOG2N].sum[0];

endmodule

// File: rtl/dm_avg_accum.sv
module dm_avg_accum #(
  parameter int NUM_IN = 16,
  parameter int SEL_W  = 3,
  localparam int LOG2N = $clog2(NUM_IN),
  localparam int CNT_W = LOG2N + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] span,
  input  logic [CNT_W-1:0] count,
  output logic             bit_q
);

  logic [LOG2N-1:0] acc_q;
  logic [CNT_W-1:0] modulus;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] total;
  logic             carry;
  logic [CNT_W-1:0] wrapped;

  always_comb begin
    modulus = CNT_W'(1) << span;
    half    = modulus >> 1;
    total   = {1'b0, acc_q} + count;
    carry   = (total >= modulus);
    wrapped = carry ? (total - modulus) : total;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= half[LOG2N-1:0];
      bit_q <= 1'b0;
    end else begin
      acc_q <= wrapped[LOG2N-1:0];
      bit_q <= carry;
    end
  end

  // R3: remainder never reaches the modulus
  assert_acc_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    {1'b0, acc_q} < modulus);

  // R4: reset centres the accumulator and clears the output
  assert_reset_centre_R4: assert property (@(posedge clk)
    rst |=> ({1'b0, acc_q} == half) && !bit_q);

  // R5: a full count always wraps
  assert_full_count_wraps_R5: assert property (@(posedge clk) disable iff (rst)
    (count == modulus) |=> bit_q);

  // R5: an empty count never wraps
  assert_empty_count_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |=> (!bit_q && $stable(acc_q)));

endmodule

// File: rtl/dm_average_adder.sv
module dm_average_adder #(
  parameter int NUM_IN = 16,
  localparam int LOG2N = $clog2(NUM_IN),
  localparam int SEL_W = $clog2(LOG2N + 1),
  localparam int CNT_W = LOG2N + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] din,
  input  logic [SEL_W-1:0]  tap_sel,
  output logic              dm_out
);

  import dm_avg_pkg::*;

  logic [SEL_W-1:0]  span_eff;
  logic [NUM_IN-1:0] din_act;
  logic [CNT_W-1:0]  ones;

  // R7: codes past the full width fold onto it
  assign span_eff = SEL_W'(clamp_span(32'(tap_sel), LOG2N));

  dm_avg_mask #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) i_mask (
    .din   (din),
    .span  (span_eff),
    .dmask (din_act)
  );

  dm_avg_tree #(.NUM_IN(NUM_IN)) i_tree (
    .bits  (din_act),
    .count (ones)
  );

  dm_avg_accum #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) i_accum (
    .clk   (clk),
    .rst   (rst),
    .span  (span_eff),
    .count (ones),
    .bit_q (dm_out)
  );

  // R1 / R6: the tree count cannot exceed the active span
  assert_count_within_span_R6: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, ones} <= ((CNT_W+1)'(1) << span_eff)));

  // R7: the effective span is never wider than the input group
  always_comb begin
    assert_span_clamped_R7: assert (32'(span_eff) <= LOG2N);
  end

endmodule

// File: tb/test_dm_average_adder.sv
`timescale 1ns/1ps
module test_dm_average_adder;

  localparam int NUM_IN = 16;
  localparam int LOG2N  = 4;
  localparam int SEL_W  = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_IN-1:0] din = '0;
  logic [SEL_W-1:0]  tap_sel = SEL_W'(LOG2N);
  logic              dm_out;

  int n_checks = 0;
  int n_fail   = 0;
  int span_s   = 1;
  int acc_m    = 0;
  int err_s    = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dm_average_adder #(.NUM_IN(NUM_IN)) i_dm_average_adder (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .tap_sel (tap_sel),
    .dm_out  (dm_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Starts and ends just after a falling edge.
  task automatic do_reset(input int code);
    int k;
    tap_sel = SEL_W'(code);
    din = '0;
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(dm_out == 1'b0, "R4 output low in reset", int'(dm_out), 0);
    rst = 1'b0;
    k = (code > LOG2N) ? LOG2N : code;
    span_s = 1 << k;
    acc_m  = span_s / 2;
    err_s  = 0;
  endtask

  task automatic cycle(input logic [NUM_IN-1:0] v, input string tag);
    int cnt, tot, b;
    din = v;
    @(posedge clk);
    cnt = 0;
    for (int i = 0; i < span_s; i++) cnt += int'(v[i]);
    tot = acc_m + cnt;
    b = (tot >= span_s) ? 1 : 0;
    acc_m = (b == 1) ? tot - span_s : tot;
    @(negedge clk);
    check(int'(dm_out) == b, tag, int'(dm_out), b);
    err_s += span_s * (2 * int'(dm_out) - 1) - (2 * cnt - span_s);
    check(err_s <= span_s && err_s >= -span_s, "R8 error bound", err_s, span_s);
  endtask

  function automatic logic [NUM_IN-1:0] rnd();
    return NUM_IN'($urandom);
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R4: full width, reset then an all-zero cycle keeps output low
    do_reset(LOG2N);
    cycle('0, "R4 first cycle after reset");
    // R5: all ones and all zeros at full width
    for (int n = 0; n < 20; n++) cycle('1, "R5 all ones");
    for (int n = 0; n < 20; n++) cycle('0, "R5 all zeros");
    // R1 / R2: random streams at full width
    for (int n = 0; n < 600; n++) cycle(rnd(), "R1 R2 random full width");
    // R2: alternating patterns
    for (int n = 0; n < 40; n++) cycle((n % 2) ? 16'hAAAA : 16'h5555, "R2 alternating");

    // R3: span 8, constant count of 3 forces irregular wraps
    do_reset(3);
    for (int n = 0; n < 40; n++) cycle(16'hFF07, "R3 wrap count 3 of 8");
    for (int n = 0; n < 300; n++) cycle(rnd(), "R3 random span 8");

    // R6: span 4, upper inputs toggle randomly and must be ignored
    do_reset(2);
    for (int n = 0; n < 30; n++) cycle({12'hFFF, 4'h0}, "R6 upper inputs ignored");
    for (int n = 0; n < 300; n++) cycle(rnd(), "R6 random span 4");

    // R9: span 1 passes input 0 through
    do_reset(0);
    for (int n = 0; n < 200; n++) cycle(rnd(), "R9 single input");

    // R7: oversize codes act as full width
    for (int code = LOG2N + 1; code < (1 << SEL_W); code++) begin
      do_reset(code);
      for (int n = 0; n < 20; n++) cycle('1, "R7 clamp all ones");
      for (int n = 0; n < 200; n++) cycle(rnd(), "R7 clamp random");
    end

    // R4: reset mid-stream restores the centred state
    do_reset(LOG2N);
    cycle(16'h00FF, "R4 reset recentres");
    cycle(16'h0001, "R4 reset recentres");

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule